// File: doc/BRIEF.md
# Trap-Mode Exponent Re-Bias Rounding Sequencer

This block rounds an extended-precision result (a sign, a wide signed exponent, a 64-bit significand with an explicit leading bit, and 64 bits of guard/round information below it) into the 80-bit extended layout. It has a 15-bit biased exponent field and a 64-bit significand. It contains one combinational round-and-pack unit. A small state machine runs that unit once or twice per operation.

The first pass rounds the operands as given. If that pass raises overflow or underflow while the matching trap is unmasked, the result must be delivered re-biased. For moderate exponents the sequencer runs the unit a second time, on the same operands, with the exponent moved by 24576 toward the representable range, and returns the second result. For exponents too extreme for that shift, it returns a signed infinity or a signed zero instead. Sticky flags from earlier operations come in with the operands and are merged into the flags that go out.

A caller pulses `start_i` while the block is idle. It then waits for the one-cycle `valid_o` pulse, which comes two cycles after the start edge, or three cycles when a second pass is needed.

Top module: `trap_rebias_round`

## Requirements
- R1: After reset, `busy_o` and `valid_o` are 0 and every result and flag output is 0.
- R2: A `start_i` seen while idle raises `busy_o` on the next cycle. `valid_o` is then high for exactly one cycle: the 2nd cycle after the start edge for a single pass, or the 3rd for a re-biased second pass. `busy_o` is low while `valid_o` is high.
- R3: Normal-range rounding follows `mode_i`: 0 = nearest-even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity. Flag bits are: bit0 inexact (guard bits nonzero), bit1 underflow, bit2 overflow, bit3 rounded-up (magnitude increased). A carry out of an all-ones significand gives exponent+1 and significand 0x8000000000000000.
- R4: An exponent above 0x7FFE, or exactly 0x7FFE with an all-ones significand that rounds up, overflows and sets bit2 and bit0. The result is infinity (exponent 0x7FFF, significand 0x8000000000000000, bit3 set) when the mode rounds away from zero for that sign. Otherwise it is the largest finite value (0x7FFE, all-ones significand).
- R5: An exponent ≤ 0 is denormalized right by 1−exponent with a sticky bit, then rounded. The exponent field becomes 1 if rounding reaches the leading bit, else 0. Underflow (bit1) is set when the shifted guard bits are nonzero, or when the underflow trap is unmasked (`trap_mask_i[0]`=0) and the input is nonzero.
- R6: When the first pass raises no underflow with `trap_mask_i[0]`=0 and no overflow with `trap_mask_i[1]`=0, the first-pass result is the output.
- R7: Otherwise, for −24576 < exponent < 24576+0x7FFF, a second pass is made with the exponent raised by 24576 (on underflow) or lowered by 24576 (on overflow). The output flags are the first pass's underflow/overflow bits OR the second pass's flags.
- R8: With a trapping first pass and exponent ≥ 24576+0x7FFF, the output is infinity of the input sign. Its flags are the first-pass flags plus inexact and rounded-up.
- R9: With a trapping first pass and exponent ≤ −24576, the output is zero of the input sign. Its flags are the first-pass flags plus inexact, with rounded-up cleared.
- R10: The output flags always include every bit of `flags_i` captured at start.
- R11: `start_i` and operand changes while an operation is in progress do not affect that operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| sign_i | input | 1 | Operand sign |
| exp_i | input | 18 | Signed unbiased-offset exponent (biased scale, may exceed range) |
| sig_i | input | 64 | Significand with explicit leading bit |
| ext_i | input | 64 | Guard/round/sticky bits below the significand |
| mode_i | input | 2 | Rounding mode |
| trap_mask_i | input | 2 | bit0 underflow masked, bit1 overflow masked |
| flags_i | input | 4 | Previously accumulated flags |
| busy_o | output | 1 | Operation in progress |
| valid_o | output | 1 | One-cycle result strobe |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | 15 | Result exponent field |
| res_sig_o | output | 64 | Result significand |
| flags_o | output | 4 | Merged result flags |

## Verification
The bound checker watches the handshake on every cycle: the single-cycle strobe, busy and valid never overlapping, and busy following an accepted start. On every result it also checks that the prior flags are kept, that an all-ones exponent carries a canonical infinity significand, and that a zero exponent never carries a set leading bit. The actual rounded values are shown only by the bench's scenarios. These are mode and tie handling, carries into the exponent, the choice between a second pass and saturation at the ±24576 limits, and the flag merge across passes, each compared against an independent model.

// File: rtl/trr_pkg.sv
package trr_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_DOWN      = 2'd2,
      RM_UP        = 2'd3
   } rmode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PASS1,
      ST_PASS2,
      ST_DONE
   } seq_state_e;

   localparam int FLAG_W     = 4;
   localparam int FL_INEXACT = 0;
   localparam int FL_UNDER   = 1;
   localparam int FL_OVER    = 2;
   localparam int FL_UPWARD  = 3;

   // decide whether the discarded part forces a one-ulp increment
   function automatic logic want_inc(rmode_e m, logic neg, logic half, logic nz);
      case (m)
         RM_NEAR_EVEN: return half;
         RM_DOWN:      return neg & nz;
         RM_UP:        return !neg & nz;
         default:      return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/trr_jam_shift.sv
// Right shift with all shifted-out ones folded into the result LSB.
module trr_jam_shift #(
   parameter int W    = 128,
   parameter int SH_W = 19
) (
   input  logic [W-1:0]    vec_i,
   input  logic [SH_W-1:0] amt_i,
   output logic [W-1:0]    vec_o
);
   logic [W-1:0] kept;
   logic         lost;

   always_comb begin
      kept  = vec_i >> amt_i;
      lost  = |(vec_i & ~({W{1'b1}} << amt_i));
      vec_o = kept | {{(W-1){1'b0}}, lost};
   end
endmodule

// File: rtl/trr_round_core.sv
module trr_round_core
   import trr_pkg::*;
#(
   parameter int SIG_W  = 64,
   parameter int EXT_W  = 64,
   parameter int EXP_W  = 18,
   parameter int EFLD_W = 15
) (
   input  logic                    sign_i,
   input  logic signed [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0]        sig_i,
   input  logic [EXT_W-1:0]        ext_i,
   input  logic [1:0]              mode_i,
   input  logic                    uf_masked_i,
   output logic [EFLD_W-1:0]       exp_o,
   output logic [SIG_W-1:0]        sig_o,
   output logic [FLAG_W-1:0]       flags_o
);
   localparam int TW   = SIG_W + EXT_W;
   localparam int EMAX = (1 << EFLD_W) - 1;
   localparam logic signed [EXP_W-1:0] E_EDGE = EXP_W'(EMAX - 1);
   localparam logic [EXT_W-1:0]  HALF = {1'b1, {(EXT_W-1){1'b0}}};
   localparam logic [SIG_W-1:0]  LEAD = {1'b1, {(SIG_W-1){1'b0}}};

   rmode_e            m;
   logic [EXP_W:0]    shamt;
   logic [TW-1:0]     den;
   logic [SIG_W-1:0]  den_sig;
   logic [EXT_W-1:0]  den_ext;
   logic              inc_n, inc_d, is_tiny, is_ovf, away;
   logic [SIG_W:0]    sum_n, sum_d;
   logic [SIG_W-1:0]  rnd;

   assign m     = rmode_e'(mode_i);
   assign shamt = (EXP_W+1)'(1) - {exp_i[EXP_W-1], exp_i};

   trr_jam_shift #(.W(TW), .SH_W(EXP_W+1)) u_jam (
      .vec_i ({sig_i, ext_i}),
      .amt_i (shamt),
      .vec_o (den)
   );

   assign den_sig = den[TW-1 -: SIG_W];
   assign den_ext = den[EXT_W-1:0];
   assign inc_n   = want_inc(m, sign_i, ext_i[EXT_W-1], |ext_i);
   assign inc_d   = want_inc(m, sign_i, den_ext[EXT_W-1], |den_ext);
   assign sum_n   = {1'b0, sig_i} + (SIG_W+1)'(inc_n);
   assign sum_d   = {1'b0, den_sig} + (SIG_W+1)'(inc_d);
   assign is_tiny = exp_i[EXP_W-1] | (exp_i == '0);
   assign is_ovf  = (exp_i > E_EDGE) | ((exp_i == E_EDGE) & (&sig_i) & inc_n);
   assign away    = (m == RM_NEAR_EVEN) | ((m == RM_UP) & !sign_i) | ((m == RM_DOWN) & sign_i);

   always_comb begin
      exp_o   = '0;
      sig_o   = '0;
      flags_o = '0;
      rnd     = '0;
      if (is_tiny) begin
         rnd = sum_d[SIG_W-1:0];
         if ((m == RM_NEAR_EVEN) && (den_ext == HALF)) rnd[0] = 1'b0;
         sig_o                = rnd;
         exp_o                = EFLD_W'(rnd[SIG_W-1]);
         flags_o[FL_INEXACT]  = |den_ext;
         flags_o[FL_UNDER]    = (|den_ext) | (!uf_masked_i & (|{sig_i, ext_i}));
         flags_o[FL_UPWARD]   = rnd > den_sig;
      end else if (is_ovf) begin
         flags_o[FL_OVER]    = 1'b1;
         flags_o[FL_INEXACT] = 1'b1;
         if (away) begin
            exp_o              = {EFLD_W{1'b1}};
            sig_o              = LEAD;
            flags_o[FL_UPWARD] = 1'b1;
         end else begin
            exp_o = {{(EFLD_W-1){1'b1}}, 1'b0};
            sig_o = '1;
         end
      end else begin
         flags_o[FL_INEXACT] = |ext_i;
         if (sum_n[SIG_W]) begin
            exp_o              = exp_i[EFLD_W-1:0] + 1'b1;
            sig_o              = LEAD;
            flags_o[FL_UPWARD] = 1'b1;
         end else begin
            rnd = sum_n[SIG_W-1:0];
            if ((m == RM_NEAR_EVEN) && (ext_i == HALF)) rnd[0] = 1'b0;
            sig_o              = rnd;
            exp_o              = exp_i[EFLD_W-1:0];
            flags_o[FL_UPWARD] = rnd > sig_i;
         end
      end
   end
endmodule

// File: rtl/trap_rebias_round.sv
module trap_rebias_round
   import trr_pkg::*;
#(
   parameter int SIG_W    = 64,
   parameter int EXT_W    = 64,
   parameter int EXP_W    = 18,
   parameter int EFLD_W   = 15,
   parameter int BIAS_ADJ = 24576
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    sign_i,
   input  logic signed [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0]        sig_i,
   input  logic [EXT_W-1:0]        ext_i,
   input  logic [1:0]              mode_i,
   input  logic [1:0]              trap_mask_i,
   input  logic [FLAG_W-1:0]       flags_i,
   output logic                    busy_o,
   output logic                    valid_o,
   output logic                    res_sign_o,
   output logic [EFLD_W-1:0]       res_exp_o,
   output logic [SIG_W-1:0]        res_sig_o,
   output logic [FLAG_W-1:0]       flags_o
);
   localparam int EMAX = (1 << EFLD_W) - 1;
   localparam logic signed [EXP_W-1:0] BIAS_X = EXP_W'(BIAS_ADJ);
   localparam logic signed [EXP_W-1:0] HI_LIM = EXP_W'(BIAS_ADJ + EMAX);
   localparam logic signed [EXP_W-1:0] LO_LIM = EXP_W'(-BIAS_ADJ);
   localparam logic [FLAG_W-1:0] M_PE  = FLAG_W'(1) << FL_INEXACT;
   localparam logic [FLAG_W-1:0] M_UP  = FLAG_W'(1) << FL_UPWARD;
   localparam logic [FLAG_W-1:0] M_EXC = (FLAG_W'(1) << FL_UNDER) | (FLAG_W'(1) << FL_OVER);

   if (EXP_W < EFLD_W + 3) begin : g_bad_exp_w
      $error("exponent input too narrow for the re-bias comparisons");
   end
   if (BIAS_ADJ <= 0 || (BIAS_ADJ + EMAX) >= (1 << (EXP_W - 1))) begin : g_bad_bias
      $error("bias adjust out of range for the exponent width");
   end
   if (SIG_W < 2 || EXT_W < 2) begin : g_bad_sig
      $error("significand and guard widths must be at least 2");
   end

   seq_state_e              state;
   logic                    op_sign;
   logic signed [EXP_W-1:0] op_exp, adj_exp, core_exp;
   logic [SIG_W-1:0]        op_sig;
   logic [EXT_W-1:0]        op_ext;
   logic [1:0]              op_mode, op_mask;
   logic [FLAG_W-1:0]       op_flags, p1_flags;
   logic [EFLD_W-1:0]       c_exp;
   logic [SIG_W-1:0]        c_sig;
   logic [FLAG_W-1:0]       c_flags;
   logic                    trap1;

   assign core_exp = (state == ST_PASS2) ? adj_exp : op_exp;

   trr_round_core #(
      .SIG_W (SIG_W), .EXT_W (EXT_W), .EXP_W (EXP_W), .EFLD_W (EFLD_W)
   ) u_core (
      .sign_i      (op_sign),
      .exp_i       (core_exp),
      .sig_i       (op_sig),
      .ext_i       (op_ext),
      .mode_i      (op_mode),
      .uf_masked_i (op_mask[0]),
      .exp_o       (c_exp),
      .sig_o       (c_sig),
      .flags_o     (c_flags)
   );

   assign trap1 = (c_flags[FL_UNDER] & !op_mask[0]) | (c_flags[FL_OVER] & !op_mask[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         op_sign    <= 1'b0;
         op_exp     <= '0;
         op_sig     <= '0;
         op_ext     <= '0;
         op_mode    <= '0;
         op_mask    <= '0;
         op_flags   <= '0;
         p1_flags   <= '0;
         adj_exp    <= '0;
         res_sign_o <= 1'b0;
         res_exp_o  <= '0;
         res_sig_o  <= '0;
         flags_o    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               op_sign  <= sign_i;
               op_exp   <= exp_i;
               op_sig   <= sig_i;
               op_ext   <= ext_i;
               op_mode  <= mode_i;
               op_mask  <= trap_mask_i;
               op_flags <= flags_i;
               state    <= ST_PASS1;
            end
            ST_PASS1: begin
               p1_flags   <= c_flags;
               res_sign_o <= op_sign;
               state      <= ST_DONE;
               if (!trap1) begin
                  res_exp_o <= c_exp;
                  res_sig_o <= c_sig;
                  flags_o   <= c_flags | op_flags;
               end else if (op_exp >= HI_LIM) begin
                  res_exp_o <= {EFLD_W{1'b1}};
                  res_sig_o <= {1'b1, {(SIG_W-1){1'b0}}};
                  flags_o   <= c_flags | M_PE | M_UP | op_flags;
               end else if (op_exp <= LO_LIM) begin
                  res_exp_o <= '0;
                  res_sig_o <= '0;
                  flags_o   <= (c_flags & ~M_UP) | M_PE | op_flags;
               end else begin
                  adj_exp <= c_flags[FL_UNDER] ? op_exp + BIAS_X : op_exp - BIAS_X;
                  state   <= ST_PASS2;
               end
            end
            ST_PASS2: begin
               res_exp_o <= c_exp;
               res_sig_o <= c_sig;
               flags_o   <= (p1_flags & M_EXC) | c_flags | op_flags;
               state     <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state == ST_PASS1) || (state == ST_PASS2);
   assign valid_o = (state == ST_DONE);

endmodule

// File: rtl/trr_checks.sv
module trr_checks #(
   parameter int SIG_W  = 64,
   parameter int EFLD_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              valid_o,
   input logic [EFLD_W-1:0] res_exp_o,
   input logic [SIG_W-1:0]  res_sig_o,
   input logic [3:0]        flags_o,
   input logic [3:0]        saved_flags
);
   localparam logic [SIG_W-1:0] LEAD = {1'b1, {(SIG_W-1){1'b0}}};

   p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   p_busy_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && valid_o));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !valid_o) |=> busy_o);

   p_valid_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(busy_o));

   p_keep_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((flags_o & saved_flags) == saved_flags));

   p_inf_canon_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && (&res_exp_o)) |-> (res_sig_o == LEAD));

   p_no_pseudo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && (res_exp_o == '0)) |-> !res_sig_o[SIG_W-1]);
endmodule

bind trap_rebias_round trr_checks #(.SIG_W(SIG_W), .EFLD_W(EFLD_W)) u_checks (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .valid_o     (valid_o),
   .res_exp_o   (res_exp_o),
   .res_sig_o   (res_sig_o),
   .flags_o     (flags_o),
   .saved_flags (op_flags)
);

// File: tb/trap_rebias_round_tb.sv
module trap_rebias_round_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BIAS = 24576;

   typedef struct packed {
      logic [14:0] e;
      logic [63:0] s;
      logic [3:0]  f;
   } mres_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        sign_i = 1'b0;
   logic signed [17:0] exp_i = '0;
   logic [63:0] sig_i = '0;
   logic [63:0] ext_i = '0;
   logic [1:0]  mode_i = '0;
   logic [1:0]  trap_mask_i = '0;
   logic [3:0]  flags_i = '0;
   logic        busy_o, valid_o, res_sign_o;
   logic [14:0] res_exp_o;
   logic [63:0] res_sig_o;
   logic [3:0]  flags_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_rebias_round dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sign_i(sign_i), .exp_i(exp_i),
      .sig_i(sig_i), .ext_i(ext_i), .mode_i(mode_i), .trap_mask_i(trap_mask_i),
      .flags_i(flags_i), .busy_o(busy_o), .valid_o(valid_o), .res_sign_o(res_sign_o),
      .res_exp_o(res_exp_o), .res_sig_o(res_sig_o), .flags_o(flags_o)
   );

   task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit m_inc(int md, bit sg, bit [63:0] x);
      if (md == 0) return x[63];
      if (md == 2) return sg && (x != 0);
      if (md == 3) return !sg && (x != 0);
      return 1'b0;
   endfunction

   // independent single-pass rounding model (R3, R4, R5)
   function automatic mres_t m_round(bit sg, int e, bit [63:0] s, bit [63:0] x, int md, bit ufm);
      mres_t r = '0;
      bit [127:0] v = {s, x};
      bit [64:0] t;
      bit inc = m_inc(md, sg, x);
      if (e <= 0) begin
         int n = 1 - e;
         bit [127:0] w;
         if (n >= 128) w = (v != 0) ? 128'd1 : 128'd0;
         else begin
            w = v >> n;
            if ((v << (128 - n)) != 0) w[0] = 1'b1;
         end
         t = {1'b0, w[127:64]} + 65'(m_inc(md, sg, w[63:0]));
         if (md == 0 && w[63:0] == 64'h8000_0000_0000_0000) t[0] = 1'b0;
         r.s = t[63:0];
         r.e = {14'd0, t[63]};
         r.f[0] = w[63:0] != 0;
         r.f[1] = (w[63:0] != 0) || (!ufm && v != 0);
         r.f[3] = t[63:0] > w[127:64];
      end else if (e > 32766 || (e == 32766 && s == '1 && inc)) begin
         r.f[2] = 1'b1;
         r.f[0] = 1'b1;
         if (md == 0 || (md == 3 && !sg) || (md == 2 && sg)) begin
            r.e = 15'h7FFF; r.s = 64'h8000_0000_0000_0000; r.f[3] = 1'b1;
         end else begin
            r.e = 15'h7FFE; r.s = '1;
         end
      end else begin
         t = {1'b0, s} + 65'(inc);
         r.f[0] = x != 0;
         if (t[64]) begin
            r.e = 15'(e + 1); r.s = 64'h8000_0000_0000_0000; r.f[3] = 1'b1;
         end else begin
            if (md == 0 && x == 64'h8000_0000_0000_0000) t[0] = 1'b0;
            r.s = t[63:0]; r.e = 15'(e); r.f[3] = t[63:0] > s;
         end
      end
      return r;
   endfunction

   function automatic mres_t m_top(bit sg, int e, bit [63:0] s, bit [63:0] x, int md,
                                   bit [1:0] msk, bit [3:0] fin, output int lat, output string tag);
      mres_t r1 = m_round(sg, e, s, x, md, msk[0]);
      mres_t r;
      lat = 2;
      tag = (r1.f[2]) ? "R4" : (e <= 0) ? "R5" : "R3";
      if (!((r1.f[1] && !msk[0]) || (r1.f[2] && !msk[1]))) begin
         r = r1; r.f |= fin;
         if (r1.f[1] || r1.f[2]) tag = "R6";
      end else if (e >= BIAS + 32767) begin
         r.e = 15'h7FFF; r.s = 64'h8000_0000_0000_0000; r.f = r1.f | 4'b1001 | fin; tag = "R8";
      end else if (e <= -BIAS) begin
         r.e = '0; r.s = '0; r.f = (r1.f & 4'b0111) | 4'b0001 | fin; tag = "R9";
      end else begin
         r = m_round(sg, r1.f[1] ? e + BIAS : e - BIAS, s, x, md, msk[0]);
         r.f |= (r1.f & 4'b0110) | fin;
         lat = 3; tag = "R7";
      end
      return r;
   endfunction

   task automatic run_op(bit sg, int e, bit [63:0] s, bit [63:0] x, int md,
                         bit [1:0] msk, bit [3:0] fin, bit poke);
      int lat;
      int cyc;
      string tag;
      mres_t ex;
      @(negedge clk);
      sign_i = sg; exp_i = 18'(e); sig_i = s; ext_i = x;
      mode_i = 2'(md); trap_mask_i = msk; flags_i = fin; start_i = 1'b1;
      ex = m_top(sg, e, s, x, md, msk, fin, lat, tag);
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      check(busy_o == 1'b1, "R2 busy after start", 128'(busy_o), 128'd1);
      if (poke) begin
         start_i = 1'b1; sig_i = ~s; exp_i = 18'sd5; ext_i = ~x; sign_i = ~sg; flags_i = 4'h0;
         @(negedge clk);
         start_i = 1'b0;
         cyc = 2;
      end
      while (!valid_o && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc == lat, "R2 latency", 128'(cyc), 128'(lat));
      check({res_sign_o, res_exp_o, res_sig_o, flags_o} == {sg, ex.e, ex.s, ex.f},
            poke ? "R11 result under busy start" : tag,
            128'({res_sign_o, res_exp_o, res_sig_o, flags_o}), 128'({sg, ex.e, ex.s, ex.f}));
      check((flags_o & fin) == fin, "R10 prior flags kept", 128'(flags_o), 128'(fin));
   endtask

   function automatic int pick_exp();
      case ($urandom_range(6))
         0: return -70 + int'($urandom_range(73));
         1: return 1 + int'($urandom_range(32765));
         2: return 32760 + int'($urandom_range(15));
         3: return 32767 + int'($urandom_range(24575));
         4: return BIAS + 32767 + int'($urandom_range(7000));
         5: return -BIAS + 1 + int'($urandom_range(24500));
         default: return -40000 + int'($urandom_range(15424));
      endcase
   endfunction

   function automatic bit [63:0] pick_ext();
      case ($urandom_range(4))
         0: return 64'd0;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'd1;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      bit [63:0] s;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!busy_o && !valid_o, "R1 handshake idle", 128'({busy_o, valid_o}), 128'd0);
      check({res_sign_o, res_exp_o, res_sig_o, flags_o} == '0, "R1 outputs zero",
            128'({res_sign_o, res_exp_o, res_sig_o, flags_o}), 128'd0);

      // R3 ties, directed modes, carry into exponent
      run_op(0, 100, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0000, 0, 2'b11, 4'h0, 0);
      run_op(0, 100, 64'h8000_0000_0000_0003, 64'h8000_0000_0000_0000, 0, 2'b11, 4'h0, 0);
      run_op(1, 200, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC000_0000_0000_0000, 0, 2'b11, 4'h0, 0);
      run_op(1, 300, 64'h8000_0000_0000_0000, 64'd1, 2, 2'b11, 4'h0, 0);
      run_op(1, 300, 64'h8000_0000_0000_0000, 64'd1, 3, 2'b11, 4'h0, 0);
      // R4 overflow at the edge, masked
      run_op(0, 32766, '1, 64'h8000_0000_0000_0000, 0, 2'b11, 4'h0, 0);
      run_op(0, 32766, '1, 64'h8000_0000_0000_0000, 1, 2'b11, 4'h0, 0);
      run_op(1, 32767, 64'h8000_0000_0000_0000, 64'd0, 3, 2'b11, 4'h0, 0);
      // R5 tiny cases, masked underflow; rounding into exponent 1
      run_op(0, -3, 64'h8000_0000_0000_0007, 64'd0, 0, 2'b11, 4'h0, 0);
      run_op(0, 0, '1, 64'h8000_0000_0000_0000, 0, 2'b11, 4'h0, 0);
      // R6 zero operand with unmasked underflow
      run_op(1, -5, 64'd0, 64'd0, 0, 2'b00, 4'h0, 0);
      // R7 re-bias both directions
      run_op(0, 40000, 64'hC000_0000_0000_0001, 64'h4000_0000_0000_0000, 0, 2'b00, 4'h2, 0);
      run_op(1, -100, 64'h9000_0000_0000_0000, 64'h1, 3, 2'b00, 4'h0, 0);
      // R8 and R9 saturation
      run_op(1, 60000, 64'h8000_0000_0000_0000, 64'd0, 1, 2'b00, 4'h0, 0);
      run_op(0, -30000, 64'h8000_0000_0000_0000, 64'd0, 3, 2'b00, 4'h0, 0);
      run_op(1, -BIAS, 64'hA000_0000_0000_0000, 64'd5, 0, 2'b00, 4'h4, 0);
      run_op(0, BIAS + 32767, 64'h8000_0000_0000_0000, 64'd0, 0, 2'b01, 4'h0, 0);
      // R11 start during busy ignored, on both path lengths
      run_op(0, 1234, 64'h8765_4321_0FED_CBA9, 64'h0123_4567_89AB_CDEF, 0, 2'b11, 4'h1, 1);
      run_op(1, 45000, 64'hF000_0000_0000_0000, 64'd0, 2, 2'b00, 4'h0, 1);
      // R10 carried flags
      run_op(0, 500, 64'h8000_0000_0000_0000, 64'd0, 0, 2'b11, 4'hF, 0);

      for (int i = 0; i < 600; i++) begin
         s = {$urandom, $urandom};
         if ($urandom_range(3) != 0) s[63] = 1'b1;
         if ($urandom_range(9) == 0) s = '1;
         run_op(1'($urandom_range(1)), pick_exp(), s, pick_ext(), int'($urandom_range(3)),
                2'($urandom_range(3)), 4'($urandom_range(15)), 1'($urandom_range(15) == 0));
      end

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule